// File: doc/BRIEF.md
# Protected Page Translation Buffer

This block keeps recently used page translations so that a 32-bit virtual address can be turned into a physical address without walking the page tables. A virtual address has two parts. The low 12 bits are the byte offset inside a 4 KB page, and the upper 20 bits are the page number. The page number selects one of 16 sets. Each set has four ways, so the buffer holds 64 translations in total. Each stored translation carries the physical page number and three attribute bits from its page-table entry: the write permission, the user permission and the global bit.

A lookup is presented as a request beat with the access kind (read or write, user or supervisor). One cycle later a response beat reports one of three results: a hit with the physical address, a hit that the stored permissions forbid (a protection fault), or a miss. After a page walk, the walker writes a new translation through a fill beat. A flush pulse drops every translation except those marked global.

Both request channels use a valid/ready handshake. A beat is taken on a rising edge where valid and ready are both high. Ready is low only during a cycle in which flush is high. Flush takes priority, so a request offered in that cycle is simply not taken and must be offered again. The response side has no ready: a response beat appears exactly one cycle after each accepted lookup and is never held.

Top module: `tlbx_xlate`

## Requirements
- R1: Bits [11:0] of the lookup address are the page offset and bits [31:12] are the page number. Page-number bits [3:0] select the set, and page-number bits [19:4] are the tag compared against the stored tags.
- R2: A lookup taken on a rising edge produces a response with rsp_valid high on the next rising edge. The response is a hit only if a valid way of the selected set holds the same tag.
- R3: On a hit without a fault, rsp_pa equals the stored physical page number in bits [31:12] and the unchanged lookup offset in bits [11:0]. In every other case rsp_pa is zero.
- R4: A response with no hit raises rsp_miss. While rsp_valid is low, rsp_hit, rsp_miss and rsp_fault are all low.
- R5: A hit raises rsp_fault when it is a write and the stored write bit is clear, or when it is a user access and the stored user bit is clear. rsp_fault is never high without rsp_hit.
- R6: A fill beat supplies a page number and a 32-bit entry with this layout: physical page number in bits [31:12], global at bit 8, user at bit 2, write at bit 1, present at bit 0. A fill whose present bit is clear writes nothing.
- R7: A flush cycle invalidates every way whose global bit is clear and keeps the global ones. During that cycle lk_ready and fill_ready are low, and a lookup or fill offered then has no effect and produces no response.
- R8: A fill whose page number is already held overwrites that way, so a page never occupies two ways.
- R9: A fill of a new page into a set takes the lowest-numbered invalid way. If every way is valid, it takes the way named by that set's round-robin pointer. After reset the pointer is 0, it advances by one only on such an eviction, and a flush does not change it.
- R10: When a lookup and a fill are taken on the same edge, the lookup sees the contents as they were before that fill.
- R11: Reset invalidates all entries and clears the response. After reset both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop all non-global translations |
| lk_valid | input | 1 | Lookup request offered |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_va | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_user | input | 1 | 1 = user access, 0 = supervisor access |
| rsp_valid | output | 1 | Response beat present |
| rsp_hit | output | 1 | A valid matching translation was found |
| rsp_miss | output | 1 | No matching translation was found |
| rsp_fault | output | 1 | Hit whose permissions forbid the access |
| rsp_pa | output | 32 | Physical address, non-zero only on hit without fault |
| fill_valid | input | 1 | Fill request offered |
| fill_ready | output | 1 | Fill request can be taken |
| fill_vpn | input | 20 | Page number of the translation to store |
| fill_pte | input | 32 | Page-table entry to store |

## Verification
Two pairs of functions can meet in the same cycle. The first pair is a lookup and a fill. The bench offers a lookup and a fill of the same page on one edge and expects a miss, because the lookup reads the contents from before the fill. A lookup on the next cycle must then hit with the new physical address. The second pair is a flush together with both request channels. The bench raises flush, fill and lookup together, expects both ready outputs to be low and no response beat on the next cycle, and then shows through later lookups that the global page survived, the ordinary page was dropped, and the fill offered during the flush was never stored.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

  // Attribute positions inside a page-table entry as delivered on a fill.
  localparam int unsigned PTE_PRESENT  = 0;
  localparam int unsigned PTE_WRITABLE = 1;
  localparam int unsigned PTE_USER     = 2;
  localparam int unsigned PTE_GLOBAL   = 8;

  // True when the stored permissions forbid the access kind.
  function automatic logic access_denied(input logic is_write,
                                         input logic is_user,
                                         input logic may_write,
                                         input logic user_ok);
    return (is_write & ~may_write) | (is_user & ~user_ok);
  endfunction

endpackage

// File: rtl/tlbx_store.sv
module tlbx_store #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  parameter int PPN_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush_i,
  input  logic                              wr_en_i,
  input  logic [IDX_W-1:0]                  wr_idx_i,
  input  logic [WAY_W-1:0]                  wr_way_i,
  input  logic [TAG_W-1:0]                  wr_tag_i,
  input  logic [PPN_W-1:0]                  wr_ppn_i,
  input  logic                              wr_rw_i,
  input  logic                              wr_us_i,
  input  logic                              wr_g_i,
  input  logic [IDX_W-1:0]                  rd_idx_i,
  output logic [WAYS-1:0]                   rd_valid_o,
  output logic [WAYS-1:0][TAG_W-1:0]        rd_tag_o,
  output logic [WAYS-1:0][PPN_W-1:0]        rd_ppn_o,
  output logic [WAYS-1:0]                   rd_rw_o,
  output logic [WAYS-1:0]                   rd_us_o,
  input  logic [IDX_W-1:0]                  fl_idx_i,
  output logic [WAYS-1:0]                   fl_valid_o,
  output logic [WAYS-1:0][TAG_W-1:0]        fl_tag_o
);

  logic [SETS-1:0][WAYS-1:0] vld_q;
  logic [SETS-1:0][WAYS-1:0] rw_q;
  logic [SETS-1:0][WAYS-1:0] us_q;
  logic [SETS-1:0][WAYS-1:0] g_q;
  logic [TAG_W-1:0]          tag_q [SETS][WAYS];
  logic [PPN_W-1:0]          ppn_q [SETS][WAYS];

  // Valid bits: flush keeps only global ways, and it wins over a write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (flush_i) begin
      vld_q <= vld_q & g_q;
    end else if (wr_en_i) begin
      vld_q[wr_idx_i][wr_way_i] <= 1'b1;
    end
  end

  // Payload has no reset; it is qualified by the valid bits.
  always_ff @(posedge clk) begin
    if (wr_en_i && !flush_i) begin
      tag_q[wr_idx_i][wr_way_i] <= wr_tag_i;
      ppn_q[wr_idx_i][wr_way_i] <= wr_ppn_i;
      rw_q[wr_idx_i][wr_way_i]  <= wr_rw_i;
      us_q[wr_idx_i][wr_way_i]  <= wr_us_i;
      g_q[wr_idx_i][wr_way_i]   <= wr_g_i;
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rd_valid_o[w] = vld_q[rd_idx_i][w];
      rd_tag_o[w]   = tag_q[rd_idx_i][w];
      rd_ppn_o[w]   = ppn_q[rd_idx_i][w];
      rd_rw_o[w]    = rw_q[rd_idx_i][w];
      rd_us_o[w]    = us_q[rd_idx_i][w];
      fl_valid_o[w] = vld_q[fl_idx_i][w];
      fl_tag_o[w]   = tag_q[fl_idx_i][w];
    end
  end

  // Every way that is still valid after a flush must be a global one.
  for (genvar s = 0; s < SETS; s++) begin : g_set_chk
    for (genvar w = 0; w < WAYS; w++) begin : g_way_chk
      // R7
      flush_keeps_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !(vld_q[s][w] && !g_q[s][w]));
    end
  end

endmodule

// File: rtl/tlbx_victim.sv
module tlbx_victim #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]           new_tag_i,
  input  logic                       commit_i,
  output logic [WAY_W-1:0]           way_o
);

  logic [SETS-1:0][WAY_W-1:0] ptr_q;
  logic [WAYS-1:0]            match;
  logic                       use_ptr;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      match[w] = valid_i[w] && (tag_i[w] == new_tag_i);
    end
  end

  // Priority: a way already holding the page, then the lowest free way,
  // then the set's round-robin pointer.
  always_comb begin
    logic found;
    found   = 1'b0;
    way_o   = ptr_q[idx_i];
    for (int w = 0; w < WAYS; w++) begin
      if (!found && match[w]) begin
        way_o = WAY_W'(w);
        found = 1'b1;
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !valid_i[w]) begin
        way_o = WAY_W'(w);
        found = 1'b1;
      end
    end
    use_ptr = !found;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (commit_i && use_ptr && (idx_i == IDX_W'(s))) begin
          ptr_q[s] <= ptr_q[s] + 1'b1;
        end
      end
    end
  end

  // R8
  single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  for (genvar s = 0; s < SETS; s++) begin : g_ptr_chk
    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_i && (idx_i == IDX_W'(s))) |=> $stable(ptr_q[s]));
  end

endmodule

// File: rtl/tlbx_probe.sv
module tlbx_probe #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  parameter int PPN_W = 20
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [WAYS-1:0][PPN_W-1:0] ppn_i,
  input  logic [WAYS-1:0]            rw_i,
  input  logic [WAYS-1:0]            us_i,
  input  logic [TAG_W-1:0]           look_tag_i,
  input  logic                       is_write_i,
  input  logic                       is_user_i,
  output logic                       hit_o,
  output logic                       deny_o,
  output logic [PPN_W-1:0]           ppn_o
);

  import tlbx_pkg::*;

  always_comb begin
    hit_o  = 1'b0;
    deny_o = 1'b0;
    ppn_o  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit_o && valid_i[w] && (tag_i[w] == look_tag_i)) begin
        hit_o  = 1'b1;
        ppn_o  = ppn_i[w];
        deny_o = access_denied(is_write_i, is_user_i, rw_i[w], us_i[w]);
      end
    end
  end

endmodule

// File: rtl/tlbx_xlate.sv
module tlbx_xlate #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int PTE_W  = 32,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  localparam int VPN_W = VA_W - PAGE_W,
  localparam int PPN_W = PA_W - PAGE_W,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [VA_W-1:0]  lk_va,
  input  logic             lk_write,
  input  logic             lk_user,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_pa,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PTE_W-1:0] fill_pte
);

  import tlbx_pkg::*;

  // Address fields of the lookup and of the fill.
  logic [PAGE_W-1:0] lk_off;
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic [IDX_W-1:0]  fl_idx;
  logic [TAG_W-1:0]  fl_tag;
  logic [PPN_W-1:0]  fl_ppn;
  logic              lk_take;
  logic              fl_take;
  logic              unused_pte;

  assign lk_off = lk_va[PAGE_W-1:0];
  assign lk_idx = lk_va[PAGE_W +: IDX_W];
  assign lk_tag = lk_va[PAGE_W+IDX_W +: TAG_W];
  assign fl_idx = fill_vpn[IDX_W-1:0];
  assign fl_tag = fill_vpn[IDX_W +: TAG_W];
  assign fl_ppn = fill_pte[PAGE_W +: PPN_W];
  assign unused_pte = ^fill_pte;

  // Flush stalls both request channels for its cycle.
  assign lk_ready   = ~flush;
  assign fill_ready = ~flush;
  assign lk_take    = lk_valid & lk_ready;
  assign fl_take    = fill_valid & fill_ready & fill_pte[PTE_PRESENT];

  logic [WAYS-1:0]            rd_valid;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0][PPN_W-1:0] rd_ppn;
  logic [WAYS-1:0]            rd_rw;
  logic [WAYS-1:0]            rd_us;
  logic [WAYS-1:0]            fs_valid;
  logic [WAYS-1:0][TAG_W-1:0] fs_tag;
  logic [WAY_W-1:0]           fill_way;

  tlbx_store #(
    .SETS (SETS),
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .PPN_W(PPN_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_i   (flush),
    .wr_en_i   (fl_take),
    .wr_idx_i  (fl_idx),
    .wr_way_i  (fill_way),
    .wr_tag_i  (fl_tag),
    .wr_ppn_i  (fl_ppn),
    .wr_rw_i   (fill_pte[PTE_WRITABLE]),
    .wr_us_i   (fill_pte[PTE_USER]),
    .wr_g_i    (fill_pte[PTE_GLOBAL]),
    .rd_idx_i  (lk_idx),
    .rd_valid_o(rd_valid),
    .rd_tag_o  (rd_tag),
    .rd_ppn_o  (rd_ppn),
    .rd_rw_o   (rd_rw),
    .rd_us_o   (rd_us),
    .fl_idx_i  (fl_idx),
    .fl_valid_o(fs_valid),
    .fl_tag_o  (fs_tag)
  );

  tlbx_victim #(
    .SETS (SETS),
    .WAYS (WAYS),
    .TAG_W(TAG_W)
  ) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_i    (fl_idx),
    .valid_i  (fs_valid),
    .tag_i    (fs_tag),
    .new_tag_i(fl_tag),
    .commit_i (fl_take),
    .way_o    (fill_way)
  );

  logic             pr_hit;
  logic             pr_deny;
  logic [PPN_W-1:0] pr_ppn;

  tlbx_probe #(
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .PPN_W(PPN_W)
  ) u_probe (
    .valid_i   (rd_valid),
    .tag_i     (rd_tag),
    .ppn_i     (rd_ppn),
    .rw_i      (rd_rw),
    .us_i      (rd_us),
    .look_tag_i(lk_tag),
    .is_write_i(lk_write),
    .is_user_i (lk_user),
    .hit_o     (pr_hit),
    .deny_o    (pr_deny),
    .ppn_o     (pr_ppn)
  );

  // Registered response, one cycle after the lookup is taken.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= lk_take;
      rsp_hit   <= lk_take & pr_hit;
      rsp_miss  <= lk_take & ~pr_hit;
      rsp_fault <= lk_take & pr_hit & pr_deny;
      rsp_pa    <= (lk_take && pr_hit && !pr_deny) ? {pr_ppn, lk_off} : '0;
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);

  // R4
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss));

  // R4
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

  // R5
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit);

  // R3
  offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> (!(rsp_hit && !rsp_fault) ||
                                (rsp_pa[PAGE_W-1:0] == $past(lk_off))));

  // R3
  pa_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && !rsp_fault) |-> (rsp_pa == '0));

endmodule

// File: tb/tlbx_xlate_test.sv
`timescale 1ns/1ps
module tlbx_xlate_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_va = '0;
  logic        lk_write = 1'b0;
  logic        lk_user = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_pa;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [19:0] fill_vpn = '0;
  logic [31:0] fill_pte = '0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tlbx_xlate uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_va(lk_va),
    .lk_write(lk_write), .lk_user(lk_user),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_vpn(fill_vpn), .fill_pte(fill_pte)
  );

  // Result classes: 0 miss, 1 hit allowed, 2 hit with fault.
  typedef struct packed {
    logic [1:0]  op;    // 1 fill, 2 lookup
    logic [31:0] a;     // fill: page number; lookup: address
    logic [31:0] pte;
    logic        wr;
    logic        usr;
    logic [1:0]  cls;
    logic [31:0] epa;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 32'h0000_0012, 32'hABCD_E007, 1'b0, 1'b0, 2'd0, 32'h0},
    '{2'd2, 32'h0001_2345, 32'h0,         1'b0, 1'b1, 2'd1, 32'hABCD_E345}, // R1 R3
    '{2'd2, 32'h0001_3345, 32'h0,         1'b0, 1'b0, 2'd0, 32'h0},         // R1 other set
    '{2'd2, 32'h0011_2000, 32'h0,         1'b0, 1'b0, 2'd0, 32'h0},         // R2 tag differs
    '{2'd1, 32'h0000_0022, 32'h1111_1005, 1'b0, 1'b0, 2'd0, 32'h0},
    '{2'd2, 32'h0002_2010, 32'h0,         1'b1, 1'b1, 2'd2, 32'h0},         // R5 write read-only
    '{2'd2, 32'h0002_2010, 32'h0,         1'b0, 1'b1, 2'd1, 32'h1111_1010},
    '{2'd1, 32'h0000_0032, 32'h2222_2003, 1'b0, 1'b0, 2'd0, 32'h0},
    '{2'd2, 32'h0003_2FFF, 32'h0,         1'b0, 1'b1, 2'd2, 32'h0},         // R5 user on supervisor
    '{2'd2, 32'h0003_2FFF, 32'h0,         1'b1, 1'b0, 2'd1, 32'h2222_2FFF},
    '{2'd1, 32'h0000_0012, 32'h3333_3007, 1'b0, 1'b0, 2'd0, 32'h0},         // R8 refill
    '{2'd2, 32'h0001_2001, 32'h0,         1'b0, 1'b0, 2'd1, 32'h3333_3001}, // R8
    '{2'd1, 32'h0000_0042, 32'h4444_4006, 1'b0, 1'b0, 2'd0, 32'h0},         // R6 not present
    '{2'd2, 32'h0004_2000, 32'h0,         1'b0, 1'b0, 2'd0, 32'h0}          // R6
  };

  task automatic check(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [31:0] pte);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pte = pte;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // Response packed as {valid, miss, hit, fault, pa}.
  function automatic logic [35:0] expect_rsp(input logic [1:0] cls,
                                             input logic [31:0] epa);
    return {1'b1, cls == 2'd0, cls != 2'd0, cls == 2'd2,
            (cls == 2'd1) ? epa : 32'h0};
  endfunction

  task automatic do_look(input logic [31:0] va, input logic wr, input logic usr,
                         input logic [1:0] cls, input logic [31:0] epa,
                         input string req);
    logic [35:0] got, exp;
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_write = wr; lk_user = usr;
    @(negedge clk);
    lk_valid = 1'b0;
    got = {rsp_valid, rsp_miss, rsp_hit, rsp_fault, rsp_pa};
    exp = expect_rsp(cls, epa);
    check(got == exp, req, 64'(got), 64'(exp));
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [35:0] got;
    repeat (3) @(negedge clk);
    // R11: reset state
    check({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_pa} == '0, "R11 rsp in reset",
          64'({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_pa}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(lk_ready && fill_ready, "R11 ready after reset",
          64'({lk_ready, fill_ready}), 64'h3);
    do_look(32'h0001_2345, 1'b0, 1'b0, 2'd0, 32'h0, "R11 empty after reset");

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].op == 2'd1)
        do_fill(TBL[i].a[19:0], TBL[i].pte);
      else
        do_look(TBL[i].a, TBL[i].wr, TBL[i].usr, TBL[i].cls, TBL[i].epa,
                $sformatf("R2 vector %0d", i));
    end

    // R9: fill set 5 beyond capacity; C is global
    do_fill(20'h00015, 32'h0A0A_0007);
    do_fill(20'h00025, 32'h0B0B_0007);
    do_fill(20'h00035, 32'h0C0C_0107);
    do_fill(20'h00045, 32'h0D0D_0007);
    do_fill(20'h00055, 32'h0E0E_0007);   // evicts way 0 (A), pointer -> 1
    do_fill(20'h00065, 32'h0F0F_0007);   // evicts way 1 (B), pointer -> 2
    do_look(32'h0001_5000, 1'b0, 1'b0, 2'd0, 32'h0, "R9 first eviction");
    do_look(32'h0002_5000, 1'b0, 1'b0, 2'd0, 32'h0, "R9 second eviction");
    do_look(32'h0004_5123, 1'b0, 1'b0, 2'd1, 32'h0D0D_0123, "R9 survivor");

    // R7: flush in the same cycle as a fill and a lookup
    do_fill(20'h00019, 32'h1919_1107);
    do_fill(20'h00029, 32'h2929_2007);
    @(negedge clk);
    flush = 1'b1;
    fill_valid = 1'b1; fill_vpn = 20'h00039; fill_pte = 32'h3939_3007;
    lk_valid = 1'b1; lk_va = 32'h0001_9000; lk_write = 1'b0; lk_user = 1'b0;
    #1;
    check(!lk_ready && !fill_ready, "R7 ready low in flush",
          64'({lk_ready, fill_ready}), 64'h0);
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0; lk_valid = 1'b0;
    got = {rsp_valid, rsp_miss, rsp_hit, rsp_fault, rsp_pa};
    check(got == '0, "R7 R4 no response to stalled lookup", 64'(got), 64'h0);
    do_look(32'h0001_9abc, 1'b0, 1'b0, 2'd1, 32'h1919_1abc, "R7 global kept");
    do_look(32'h0002_9abc, 1'b0, 1'b0, 2'd0, 32'h0, "R7 non-global dropped");
    do_look(32'h0003_9abc, 1'b0, 1'b0, 2'd0, 32'h0, "R7 fill in flush ignored");
    do_look(32'h0006_5000, 1'b0, 1'b0, 2'd0, 32'h0, "R7 set 5 dropped");

    // R9: free ways first (0,1,3), then pointer (2) evicts global C
    do_fill(20'h00075, 32'h7777_0007);
    do_fill(20'h00085, 32'h8888_0007);
    do_fill(20'h00095, 32'h9999_0007);
    do_look(32'h0003_5000, 1'b0, 1'b0, 2'd1, 32'h0C0C_0000, "R9 free ways used first");
    do_fill(20'h000A5, 32'hAAAA_0007);
    do_look(32'h0003_5000, 1'b0, 1'b0, 2'd0, 32'h0, "R9 pointer kept over flush");
    do_look(32'h0007_5004, 1'b0, 1'b0, 2'd1, 32'h7777_0004, "R9 G kept");
    do_look(32'h0009_5008, 1'b0, 1'b0, 2'd1, 32'h9999_0008, "R9 I kept");
    do_look(32'h000A_500C, 1'b1, 1'b1, 2'd1, 32'hAAAA_000C, "R9 J stored");

    // R10: lookup and fill of the same page on one edge
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'h0001B; fill_pte = 32'h5555_5007;
    lk_valid = 1'b1; lk_va = 32'h0001_BABC; lk_write = 1'b0; lk_user = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    got = {rsp_valid, rsp_miss, rsp_hit, rsp_fault, rsp_pa};
    check(got == expect_rsp(2'd0, 32'h0), "R10 same-edge lookup misses",
          64'(got), 64'(expect_rsp(2'd0, 32'h0)));
    do_look(32'h0001_BABC, 1'b0, 1'b1, 2'd1, 32'h5555_5ABC, "R10 next lookup hits");

    // R11: reset clears entries
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_look(32'h0002_2010, 1'b0, 1'b1, 2'd0, 32'h0, "R11 reset invalidates");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule